// File: doc/BRIEF.md
# Decoded Micro-op Cache Array

This block is the storage side of a decoded micro-op cache. Code is handled in aligned 32-byte chunks. A line builder sends fill records. Each record describes one way's worth of decoded micro-ops: up to six, all taken from one contiguous run of instructions inside one chunk. The array files each record into the one set that the chunk maps to, next to a tag, the byte offset of the run's first instruction, and the byte offset just past its last instruction. No chunk may hold more than three ways, so at most eighteen micro-ops are kept per chunk.

The fetch side presents a fetch address. The array answers with a registered hit or miss. On a hit it streams the chunk's micro-ops in program order, starting at the way that begins exactly at the requested offset. After each way it moves on to the way of the same chunk that begins where the previous one ended. Each beat carries up to four micro-ops, and the consumer can stall the stream with a ready signal. A chunk can be invalidated as a whole. When a set is full, replacement picks a victim by tree pseudo-LRU, and every way of the victim's chunk is dropped together with it.

Top module: `uc_array`

## Requirements
- R1: Address bits [9:5] select the set and bits [31:10] form the tag. Chunks that differ only in tag share a set, and up to 8 of them coexist in it.
- R2: A fill record takes its start offset from `fill_addr[4:0]`, its end offset from `fill_end` (1..32) and its micro-op count from `fill_count` (1..6). Micro-op i sits in `fill_uops[16*i +: 16]`, with i=0 first in program order.
- R3: One cycle after a lookup is accepted, `rsp_valid` pulses. `rsp_hit` is 1 only if a valid way of that chunk starts exactly at `lk_addr[4:0]`. A miss produces no beats.
- R4: On a hit, beats deliver micro-ops in program order, lane 0 (`out_uops[15:0]`) first. A beat carries 1..4 micro-ops and never mixes two ways. Unused lanes are zero. After a way, readout continues with the chunk's way whose start offset equals that way's end offset. `out_last` marks the final beat.
- R5: While `out_valid` is high and `out_ready` is low, `out_count`, `out_uops` and `out_last` hold. No micro-op is lost or repeated.
- R6: `lk_ready` is low from the cycle after a hit is accepted until the final beat has been produced.
- R7: A fill for a chunk that already owns 3 ways in its set is not stored, and all ways of that chunk are cleared.
- R8: A fill whose chunk already has a valid way with the same start offset is dropped. The stored micro-ops remain.
- R9: A fill uses the lowest-numbered free way of its set. If no way is free, it uses the tree pseudo-LRU victim. Fills and lookup hits count as uses.
- R10: Evicting a victim way also clears every other way tagged with the victim's chunk.
- R11: `inv_valid` clears every way of the named chunk in one cycle. A fill presented in that same cycle is ignored.
- R12: After reset all ways are invalid, `out_valid` and `rsp_valid` are low and `lk_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_valid | input | 1 | Fill record present this cycle |
| fill_addr | input | 32 | Chunk address and start offset of the record |
| fill_end | input | 6 | Byte offset just past the last instruction |
| fill_count | input | 3 | Micro-ops in the record, 1..6 |
| fill_uops | input | 96 | Micro-ops, six 16-bit lanes |
| inv_valid | input | 1 | Invalidate chunk request |
| inv_addr | input | 32 | Address inside the chunk to clear |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Fetch address of the lookup |
| lk_ready | output | 1 | Lookup can be accepted |
| rsp_valid | output | 1 | Hit/miss answer valid |
| rsp_hit | output | 1 | Lookup hit |
| out_valid | output | 1 | Beat of micro-ops valid |
| out_ready | input | 1 | Consumer takes the beat |
| out_count | output | 3 | Micro-ops in the beat, 1..4 |
| out_uops | output | 64 | Four 16-bit micro-op lanes |
| out_last | output | 1 | Final beat of the readout |

## Verification
The bench builds the array with its default geometry: 32 sets, 8 ways, 6 micro-ops per way, 3 ways per chunk and 4 lanes per beat. With these values a single set fills within ten records. That makes pseudo-LRU victim choice, whole-chunk eviction and the three-way chunk limit reachable in short sequences. Six-way and five-way runs each split into an unequal pair of beats, so the chained readout is exercised both at beat boundaries and at way boundaries. A periodic stall on `out_ready` holds beats across way switches.

// File: rtl/uc_pkg.sv
package uc_pkg;
  // code chunks are 32 bytes: 5 offset bits, end offset reaches 32
  localparam int CHUNK_OFF_W = 5;
  localparam int CHUNK_END_W = 6;

  typedef enum logic {RD_IDLE, RD_STREAM} rd_state_e;
endpackage

// File: rtl/uc_data_ram.sv
module uc_data_ram #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 96
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [WIDTH-1:0]         wdata,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [WIDTH-1:0]         rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/uc_plru.sv
module uc_plru #(
  parameter int SETS = 32,
  parameter int WAYS = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    a_en,
  input  logic [$clog2(SETS)-1:0] a_set,
  input  logic [$clog2(WAYS)-1:0] a_way,
  input  logic                    b_en,
  input  logic [$clog2(SETS)-1:0] b_set,
  input  logic [$clog2(WAYS)-1:0] b_way,
  input  logic [$clog2(SETS)-1:0] q_set,
  output logic [$clog2(WAYS)-1:0] victim
);
  localparam int WAY_W = $clog2(WAYS);
  localparam int NODES = WAYS - 1;

  // node bit 1: victim lies in the upper half below that node
  logic [NODES-1:0] tree_q [SETS];

  function automatic logic [NODES-1:0] touch(input logic [NODES-1:0] t,
                                             input logic [WAY_W-1:0] w);
    logic [NODES-1:0] r;
    int node;
    r = t;
    node = 1;
    for (int l = 0; l < WAY_W; l++) begin
      r[node-1] = ~w[WAY_W-1-l];
      node = node * 2 + int'(w[WAY_W-1-l]);
    end
    return r;
  endfunction

  always_comb begin
    int node;
    node = 1;
    victim = '0;
    for (int l = 0; l < WAY_W; l++) begin
      victim[WAY_W-1-l] = tree_q[q_set][node-1];
      node = node * 2 + int'(tree_q[q_set][node-1]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else begin
      if (b_en) tree_q[b_set] <= touch(tree_q[b_set], b_way);
      if (a_en && !(b_en && b_set == a_set))
        tree_q[a_set] <= touch(tree_q[a_set], a_way);
    end
  end
endmodule

// File: rtl/uc_reader.sv
module uc_reader
  import uc_pkg::*;
#(
  parameter int SETS       = 32,
  parameter int WAYS       = 8,
  parameter int WAY_UOPS   = 6,
  parameter int CHUNK_WAYS = 3,
  parameter int UOP_W      = 16,
  parameter int LANES      = 4,
  parameter int TAG_W      = 22
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 start,
  input  logic [$clog2(SETS)-1:0]              start_set,
  input  logic [$clog2(WAYS)-1:0]              start_way,
  input  logic [TAG_W-1:0]                     start_tag,
  input  logic [WAYS-1:0]                      row_vld,
  input  logic [WAYS*TAG_W-1:0]                row_tag,
  input  logic [WAYS*CHUNK_OFF_W-1:0]          row_st,
  input  logic [WAYS*CHUNK_END_W-1:0]          row_end,
  input  logic [WAYS*$clog2(WAY_UOPS+1)-1:0]   row_cnt,
  input  logic [WAY_UOPS*UOP_W-1:0]            ram_q,
  input  logic                                 out_ready,
  output logic                                 busy,
  output logic [$clog2(SETS)-1:0]              cur_set,
  output logic                                 ram_re,
  output logic [$clog2(SETS*WAYS)-1:0]         ram_raddr,
  output logic                                 out_valid,
  output logic [$clog2(LANES+1)-1:0]           out_count,
  output logic [LANES*UOP_W-1:0]               out_uops,
  output logic                                 out_last
);
  localparam int SET_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int CNT_W  = $clog2(WAY_UOPS + 1);
  localparam int LCNT_W = $clog2(LANES + 1);
  localparam int HOP_W  = $clog2(CHUNK_WAYS + 1);

  rd_state_e          state_q;
  logic [SET_W-1:0]   set_q;
  logic [WAY_W-1:0]   way_q;
  logic [TAG_W-1:0]   tag_q;
  logic [CNT_W-1:0]   pos_q;
  logic [HOP_W-1:0]   hops_q;

  logic [CNT_W-1:0]       cur_cnt, remain;
  logic [CHUNK_END_W-1:0] cur_end;
  logic [LCNT_W-1:0]      take;
  logic                   way_done, step, succ_ok, succ_found;
  logic [WAY_W-1:0]       succ_way;
  logic [LANES*UOP_W-1:0] lanes;

  assign cur_cnt  = row_cnt[way_q*CNT_W +: CNT_W];
  assign cur_end  = row_end[way_q*CHUNK_END_W +: CHUNK_END_W];
  assign remain   = cur_cnt - pos_q;
  assign way_done = int'(remain) <= LANES;
  assign take     = way_done ? LCNT_W'(remain) : LCNT_W'(LANES);
  assign busy     = (state_q == RD_STREAM);
  assign step     = busy && (!out_valid || out_ready);
  assign cur_set  = set_q;

  // next way of the chunk: begins where the current one ends
  always_comb begin
    succ_found = 1'b0;
    succ_way   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (row_vld[w] && row_tag[w*TAG_W +: TAG_W] == tag_q &&
          {1'b0, row_st[w*CHUNK_OFF_W +: CHUNK_OFF_W]} == cur_end) begin
        succ_found = 1'b1;
        succ_way   = WAY_W'(w);
      end
    end
  end
  assign succ_ok = succ_found && (int'(hops_q) < CHUNK_WAYS);

  always_comb begin
    lanes = '0;
    for (int i = 0; i < LANES; i++) begin
      for (int j = 0; j < WAY_UOPS; j++) begin
        if (i < int'(take) && j == int'(pos_q) + i)
          lanes[i*UOP_W +: UOP_W] = ram_q[j*UOP_W +: UOP_W];
      end
    end
  end

  assign ram_re    = start || (step && way_done && succ_ok);
  assign ram_raddr = start ? {start_set, start_way} : {set_q, succ_way};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= RD_IDLE;
      out_valid <= 1'b0;
      out_count <= '0;
      out_uops  <= '0;
      out_last  <= 1'b0;
      set_q     <= '0;
      way_q     <= '0;
      tag_q     <= '0;
      pos_q     <= '0;
      hops_q    <= '0;
    end else begin
      if (step) begin
        out_valid <= 1'b1;
        out_count <= take;
        out_uops  <= lanes;
        if (way_done) begin
          if (succ_ok) begin
            way_q    <= succ_way;
            pos_q    <= '0;
            hops_q   <= hops_q + 1'b1;
            out_last <= 1'b0;
          end else begin
            out_last <= 1'b1;
            state_q  <= RD_IDLE;
          end
        end else begin
          pos_q    <= pos_q + CNT_W'(LANES);
          out_last <= 1'b0;
        end
      end else if (out_valid && out_ready) begin
        out_valid <= 1'b0;
      end
      if (start) begin
        state_q <= RD_STREAM;
        set_q   <= start_set;
        way_q   <= start_way;
        tag_q   <= start_tag;
        pos_q   <= '0;
        hops_q  <= HOP_W'(1);
      end
    end
  end
endmodule

// File: rtl/uc_array.sv
module uc_array
  import uc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 32,
  parameter int WAYS       = 8,
  parameter int WAY_UOPS   = 6,
  parameter int CHUNK_WAYS = 3,
  parameter int UOP_W      = 16,
  parameter int LANES      = 4
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                fill_valid,
  input  logic [ADDR_W-1:0]                   fill_addr,
  input  logic [CHUNK_END_W-1:0]              fill_end,
  input  logic [$clog2(WAY_UOPS+1)-1:0]       fill_count,
  input  logic [WAY_UOPS*UOP_W-1:0]           fill_uops,
  input  logic                                inv_valid,
  input  logic [ADDR_W-1:0]                   inv_addr,
  input  logic                                lk_valid,
  input  logic [ADDR_W-1:0]                   lk_addr,
  output logic                                lk_ready,
  output logic                                rsp_valid,
  output logic                                rsp_hit,
  output logic                                out_valid,
  input  logic                                out_ready,
  output logic [$clog2(LANES+1)-1:0]          out_count,
  output logic [LANES*UOP_W-1:0]              out_uops,
  output logic                                out_last
);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - CHUNK_OFF_W - SET_W;
  localparam int CNT_W = $clog2(WAY_UOPS + 1);

  logic [WAYS-1:0]        vld_q [SETS];
  logic [TAG_W-1:0]       tag_q [SETS][WAYS];
  logic [CHUNK_OFF_W-1:0] st_q  [SETS][WAYS];
  logic [CHUNK_END_W-1:0] end_q [SETS][WAYS];
  logic [CNT_W-1:0]       cnt_q [SETS][WAYS];

  // ---------------- lookup ----------------
  logic [SET_W-1:0]       lset;
  logic [TAG_W-1:0]       ltag;
  logic [CHUNK_OFF_W-1:0] loff;
  logic                   lhit, accept, start, rd_busy;
  logic [WAY_W-1:0]       lway;

  assign lset = lk_addr[CHUNK_OFF_W +: SET_W];
  assign ltag = lk_addr[ADDR_W-1 -: TAG_W];
  assign loff = lk_addr[CHUNK_OFF_W-1:0];

  always_comb begin
    lhit = 1'b0;
    lway = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (vld_q[lset][w] && tag_q[lset][w] == ltag && st_q[lset][w] == loff) begin
        lhit = 1'b1;
        lway = WAY_W'(w);
      end
    end
  end

  assign lk_ready = !rd_busy;
  assign accept   = lk_valid && lk_ready;
  assign start    = accept && lhit;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
    end else begin
      rsp_valid <= accept;
      rsp_hit   <= start;
    end
  end

  // ---------------- fill / invalidate ----------------
  logic [SET_W-1:0]       fset, iset;
  logic [TAG_W-1:0]       ftag, itag, vic_tag;
  logic [CHUNK_OFF_W-1:0] foff;
  logic [WAYS-1:0]        fmatch, imatch, vic_mask;
  logic                   fdup, free_found, fill_do, fill_kill;
  logic [WAY_W-1:0]       free_way, victim, tgt_way;

  assign fset = fill_addr[CHUNK_OFF_W +: SET_W];
  assign ftag = fill_addr[ADDR_W-1 -: TAG_W];
  assign foff = fill_addr[CHUNK_OFF_W-1:0];
  assign iset = inv_addr[CHUNK_OFF_W +: SET_W];
  assign itag = inv_addr[ADDR_W-1 -: TAG_W];

  always_comb begin
    fdup       = 1'b0;
    free_found = 1'b0;
    free_way   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      fmatch[w] = vld_q[fset][w] && tag_q[fset][w] == ftag;
      imatch[w] = vld_q[iset][w] && tag_q[iset][w] == itag;
      if (fmatch[w] && st_q[fset][w] == foff) fdup = 1'b1;
      if (!vld_q[fset][w]) begin
        free_found = 1'b1;
        free_way   = WAY_W'(w);
      end
    end
  end

  assign vic_tag = tag_q[fset][victim];
  always_comb begin
    for (int w = 0; w < WAYS; w++)
      vic_mask[w] = !free_found && vld_q[fset][w] && tag_q[fset][w] == vic_tag;
  end

  assign tgt_way   = free_found ? free_way : victim;
  assign fill_kill = fill_valid && !inv_valid && !fdup && ($countones(fmatch) >= CHUNK_WAYS);
  assign fill_do   = fill_valid && !inv_valid && !fdup && ($countones(fmatch) < CHUNK_WAYS);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (inv_valid) begin
      vld_q[iset] <= vld_q[iset] & ~imatch;
    end else if (fill_kill) begin
      vld_q[fset] <= vld_q[fset] & ~fmatch;
    end else if (fill_do) begin
      vld_q[fset] <= (vld_q[fset] & ~vic_mask) | (WAYS'(1) << tgt_way);
    end
  end

  always_ff @(posedge clk) begin
    if (fill_do) begin
      tag_q[fset][tgt_way] <= ftag;
      st_q[fset][tgt_way]  <= foff;
      end_q[fset][tgt_way] <= fill_end;
      cnt_q[fset][tgt_way] <= fill_count;
    end
  end

  uc_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
    .clk    (clk),
    .rst    (rst),
    .a_en   (start),
    .a_set  (lset),
    .a_way  (lway),
    .b_en   (fill_do),
    .b_set  (fset),
    .b_way  (tgt_way),
    .q_set  (fset),
    .victim (victim)
  );

  // ---------------- data and readout ----------------
  logic                           ram_re;
  logic [SET_W+WAY_W-1:0]         ram_raddr;
  logic [WAY_UOPS*UOP_W-1:0]      ram_q;
  logic [SET_W-1:0]               rd_set;
  logic [WAYS-1:0]                row_vld;
  logic [WAYS*TAG_W-1:0]          row_tag;
  logic [WAYS*CHUNK_OFF_W-1:0]    row_st;
  logic [WAYS*CHUNK_END_W-1:0]    row_end;
  logic [WAYS*CNT_W-1:0]          row_cnt;

  uc_data_ram #(.DEPTH(SETS*WAYS), .WIDTH(WAY_UOPS*UOP_W)) u_ram (
    .clk   (clk),
    .we    (fill_do),
    .waddr ({fset, tgt_way}),
    .wdata (fill_uops),
    .re    (ram_re),
    .raddr (ram_raddr),
    .rdata (ram_q)
  );

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_row
      assign row_vld[w]                           = vld_q[rd_set][w];
      assign row_tag[w*TAG_W +: TAG_W]            = tag_q[rd_set][w];
      assign row_st[w*CHUNK_OFF_W +: CHUNK_OFF_W] = st_q[rd_set][w];
      assign row_end[w*CHUNK_END_W +: CHUNK_END_W] = end_q[rd_set][w];
      assign row_cnt[w*CNT_W +: CNT_W]            = cnt_q[rd_set][w];
    end
  endgenerate

  uc_reader #(
    .SETS(SETS), .WAYS(WAYS), .WAY_UOPS(WAY_UOPS), .CHUNK_WAYS(CHUNK_WAYS),
    .UOP_W(UOP_W), .LANES(LANES), .TAG_W(TAG_W)
  ) u_reader (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .start_set (lset),
    .start_way (lway),
    .start_tag (ltag),
    .row_vld   (row_vld),
    .row_tag   (row_tag),
    .row_st    (row_st),
    .row_end   (row_end),
    .row_cnt   (row_cnt),
    .ram_q     (ram_q),
    .out_ready (out_ready),
    .busy      (rd_busy),
    .cur_set   (rd_set),
    .ram_re    (ram_re),
    .ram_raddr (ram_raddr),
    .out_valid (out_valid),
    .out_count (out_count),
    .out_uops  (out_uops),
    .out_last  (out_last)
  );
endmodule

// File: rtl/uc_array_chk.sv
module uc_array_chk #(
  parameter int LANES = 4,
  parameter int UOP_W = 16
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        lk_valid,
  input logic                        lk_ready,
  input logic                        rsp_valid,
  input logic                        rsp_hit,
  input logic                        out_valid,
  input logic                        out_ready,
  input logic [$clog2(LANES+1)-1:0]  out_count,
  input logic [LANES*UOP_W-1:0]      out_uops,
  input logic                        out_last
);
  p_out_hold_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_count) &&
                                $stable(out_uops) && $stable(out_last));

  p_beat_size_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_count != 0) && (int'(out_count) <= LANES));

  p_rsp_follows_r3: assert property (@(posedge clk) disable iff (rst)
    lk_valid && lk_ready |=> rsp_valid);

  p_rsp_only_r3: assert property (@(posedge clk) disable iff (rst)
    !(lk_valid && lk_ready) |=> !rsp_valid);

  p_busy_on_hit_r6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_hit |-> !lk_ready);
endmodule

bind uc_array uc_array_chk #(.LANES(LANES), .UOP_W(UOP_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .lk_valid  (lk_valid),
  .lk_ready  (lk_ready),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_count (out_count),
  .out_uops  (out_uops),
  .out_last  (out_last)
);

// File: tb/uc_array_bench.sv
module uc_array_bench;
  localparam int LANES = 4;
  localparam int UOP_W = 16;
  localparam int BEAT_W = 1 + 3 + LANES * UOP_W;

  logic        clk = 1'b0;
  logic        rst;
  logic        fill_valid = 0;
  logic [31:0] fill_addr = 0;
  logic [5:0]  fill_end = 0;
  logic [2:0]  fill_count = 0;
  logic [95:0] fill_uops = 0;
  logic        inv_valid = 0;
  logic [31:0] inv_addr = 0;
  logic        lk_valid = 0;
  logic [31:0] lk_addr = 0;
  logic        lk_ready, rsp_valid, rsp_hit, out_valid, out_last;
  logic        out_ready;
  logic [2:0]  out_count;
  logic [63:0] out_uops;

  int checks = 0;
  int fails  = 0;
  bit stall_mode = 0;
  bit finished = 0;

  logic [BEAT_W-1:0] exp_q[$];
  string             exp_tag[$];

  always #5 clk = ~clk;

  uc_array u_uc_array (
    .clk(clk), .rst(rst),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_end(fill_end),
    .fill_count(fill_count), .fill_uops(fill_uops),
    .inv_valid(inv_valid), .inv_addr(inv_addr),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_ready(lk_ready),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .out_valid(out_valid), .out_ready(out_ready), .out_count(out_count),
    .out_uops(out_uops), .out_last(out_last)
  );

  function automatic logic [15:0] uv(int t, int s, int i);
    return {t[7:0], s[4:0], i[2:0]};
  endfunction

  function automatic logic [31:0] adr(int t, int set, int off);
    return (t << 10) | (set << 5) | off;
  endfunction

  task automatic check(bit ok, string rq, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic fill(int t, int set, int s, int e, int c);
    @(posedge clk) #1;
    fill_valid = 1;
    fill_addr  = adr(t, set, s);
    fill_end   = 6'(e);
    fill_count = 3'(c);
    fill_uops  = '0;
    for (int i = 0; i < c; i++) fill_uops[i*16 +: 16] = uv(t, s, i);
    @(posedge clk) #1;
    fill_valid = 0;
  endtask

  task automatic expect_way(int t, int s, int c, bit last_way, string rq);
    for (int p = 0; p < c; p += LANES) begin
      int n;
      logic [63:0] u;
      n = (c - p > LANES) ? LANES : c - p;
      u = '0;
      for (int i = 0; i < n; i++) u[i*16 +: 16] = uv(t, s, p + i);
      exp_q.push_back({last_way && (p + n == c), 3'(n), u});
      exp_tag.push_back(rq);
    end
  endtask

  task automatic lookup(int t, int set, int off, bit exp_hit, string rq);
    do @(negedge clk); while (!lk_ready);
    @(posedge clk) #1;
    lk_valid = 1;
    lk_addr  = adr(t, set, off);
    @(posedge clk) #1;
    lk_valid = 0;
    @(negedge clk);
    check(rsp_valid === 1'b1 && rsp_hit === exp_hit, rq, "rsp", {rsp_valid, rsp_hit}, {1'b1, exp_hit});
    if (exp_hit) check(lk_ready === 1'b0, "R6", "lk_ready while streaming", lk_ready, 0);
    while (exp_q.size() != 0 || out_valid) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // consumer ready pattern
  initial begin
    int cyc = 0;
    out_ready = 1;
    forever begin
      @(posedge clk) #2;
      cyc++;
      out_ready = stall_mode ? (cyc % 3 != 0) : 1'b1;
    end
  end

  // monitor: compare delivered beats against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R3", "unexpected beat", {out_last, out_count, out_uops}, 0);
        end else begin
          logic [BEAT_W-1:0] e;
          string rq;
          e  = exp_q.pop_front();
          rq = exp_tag.pop_front();
          check({out_last, out_count, out_uops} === e, rq, "beat (R2 R4)",
                {out_last, out_count, out_uops}, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    check(lk_ready === 1'b1, "R12", "lk_ready after reset", lk_ready, 1);
    check(out_valid === 1'b0, "R12", "out_valid after reset", out_valid, 0);
    check(rsp_valid === 1'b0, "R12", "rsp_valid after reset", rsp_valid, 0);
    lookup(1, 0, 0, 0, "R12");

    // set 0: eight chunks, then PLRU victim after a hit on way 0 (R9, R1)
    for (int k = 0; k < 8; k++) fill(k, 0, 0, 12, k % 6 + 1);
    expect_way(0, 0, 1, 1, "R1");
    lookup(0, 0, 0, 1, "R1");
    fill(8, 0, 0, 12, 3);
    lookup(4, 0, 0, 0, "R9");
    expect_way(0, 0, 1, 1, "R9");
    lookup(0, 0, 0, 1, "R9");
    expect_way(8, 0, 3, 1, "R9");
    lookup(8, 0, 0, 1, "R9");
    expect_way(5, 0, 6, 1, "R1");
    lookup(5, 0, 0, 1, "R1");

    // set 1: chained three-way chunk with stalls (R4, R5)
    fill(20, 1, 0, 8, 6);
    fill(20, 1, 8, 20, 5);
    fill(20, 1, 20, 32, 3);
    stall_mode = 1;
    expect_way(20, 0, 6, 0, "R4");
    expect_way(20, 8, 5, 0, "R4");
    expect_way(20, 20, 3, 1, "R5");
    lookup(20, 1, 0, 1, "R4");
    expect_way(20, 8, 5, 0, "R4");
    expect_way(20, 20, 3, 1, "R4");
    lookup(20, 1, 8, 1, "R4");
    stall_mode = 0;
    lookup(20, 1, 5, 0, "R3");
    fill(20, 1, 8, 20, 2);                 // duplicate start, dropped
    expect_way(20, 8, 5, 0, "R8");
    expect_way(20, 20, 3, 1, "R8");
    lookup(20, 1, 8, 1, "R8");
    fill(20, 1, 12, 14, 1);                // would be a fourth way
    lookup(20, 1, 0, 0, "R7");
    lookup(20, 1, 20, 0, "R7");

    // set 2: victim chunk owns two ways, both go (R10)
    fill(30, 2, 0, 10, 2);
    fill(30, 2, 10, 32, 2);
    for (int k = 31; k <= 36; k++) fill(k, 2, 0, 4, 1);
    fill(37, 2, 0, 4, 2);
    lookup(30, 2, 10, 0, "R10");
    expect_way(37, 0, 2, 1, "R10");
    lookup(37, 2, 0, 1, "R10");
    fill(38, 2, 0, 4, 1);                  // takes freed way, no eviction
    expect_way(31, 0, 1, 1, "R10");
    lookup(31, 2, 0, 1, "R10");
    expect_way(36, 0, 1, 1, "R9");
    lookup(36, 2, 0, 1, "R9");
    expect_way(38, 0, 1, 1, "R9");
    lookup(38, 2, 0, 1, "R9");

    // set 3: invalidate (R11)
    fill(40, 3, 0, 16, 6);
    fill(40, 3, 16, 32, 4);
    fill(41, 3, 0, 8, 2);
    @(posedge clk) #1;
    inv_valid = 1;
    inv_addr  = adr(40, 3, 7);
    @(posedge clk) #1;
    inv_valid = 0;
    lookup(40, 3, 0, 0, "R11");
    lookup(40, 3, 16, 0, "R11");
    expect_way(41, 0, 2, 1, "R11");
    lookup(41, 3, 0, 1, "R11");
    @(posedge clk) #1;
    inv_valid  = 1;
    inv_addr   = adr(40, 3, 0);
    fill_valid = 1;
    fill_addr  = adr(42, 3, 0);
    fill_end   = 6'd8;
    fill_count = 3'd2;
    fill_uops  = {64'd0, uv(42, 0, 1), uv(42, 0, 0)};
    @(posedge clk) #1;
    inv_valid  = 0;
    fill_valid = 0;
    lookup(42, 3, 0, 0, "R11");

    check(exp_q.size() == 0, "R4", "beats outstanding", exp_q.size(), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule